// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation analog-to-digital converter. Software raises a start request. The sequencer then opens the sample switch so the hold capacitor stops tracking the input. It runs a series of conversion clock periods, and in each one it drives a trial code to the internal DAC and reads back one comparator decision. When the last bit is known, it publishes the code, raises a completion flag and drops its busy indication. The sample switch then closes again so the next acquisition can begin.

The conversion clock has two possible sources. The first is the system clock divided by a selectable power of two. The second is a free-running enable pulse from a separate slow oscillator. With the separate oscillator, the sequencer holds off for a fixed number of system clocks, standing for one instruction cycle, before it accepts any pulse. Software can cancel a conversion in progress. The comparator, DAC and hold capacitor are outside the block and appear only as ports.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy` is 0, `done_flag` is 0, `result` is 0, `dac_code` is 0 and `sample_on` is 1.
- R2: A `go_set` pulse while `busy` is 0 and `go_clr` is 0 makes `busy` 1 and `sample_on` 0 on the next cycle.
- R3: With `use_rc`=0 at start, one conversion period is 2^(`div_sel`+1) system clocks (`div_sel` 0 to 5). Codes 6 and 7 act as 5. Counting from the start edge, the conversion ends exactly 11 periods later. `rc_tick` has no effect in this mode.
- R4: With `use_rc`=1 at start, the sequencer waits TCY_CLKS system clocks after the start edge. After that, each cycle in which `rc_tick` is 1 counts as one period. Pulses on `rc_tick` during the wait are not counted.
- R5: The first period decides no bit. At its end `dac_code` becomes 10'h200.
- R6: Periods 2 to 11 decide bits 9 down to 0 in that order. Each bit keeps the value of `cmp_in` for that period, where 1 means the analog input is at or above `dac_code`, and the next lower bit is set as the new trial. The final code is therefore the largest code not above the input.
- R7: `result` keeps its previous value throughout a conversion. It shows the new code from the cycle after the completing edge.
- R8: On the completing edge, `busy` goes to 0, `done_flag` goes to 1 and `sample_on` goes to 1, all together.
- R9: A `go_set` pulse while `busy` is 1 is ignored, and the conversion timing and result stay unchanged.
- R10: `go_clr` while busy aborts the conversion. On the next cycle `busy` is 0 and `sample_on` is 1, while `result` and `done_flag` stay unchanged. `go_clr` takes priority over `go_set` in the same cycle.
- R11: `flag_clr` clears `done_flag` on the next cycle. If a conversion completes in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go_set | input | 1 | Start request pulse |
| go_clr | input | 1 | Software clear of the busy bit (abort) |
| flag_clr | input | 1 | Clears the completion flag |
| use_rc | input | 1 | 1 selects the separate oscillator as the conversion clock |
| div_sel | input | 3 | System clock divider code, period 2^(code+1) |
| rc_tick | input | 1 | One-cycle enable from the separate oscillator |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| busy | output | 1 | Conversion in progress (readable start bit) |
| sample_on | output | 1 | Sample switch closed |
| dac_code | output | 10 | Trial code to the DAC |
| result | output | 10 | Last completed conversion code |
| done_flag | output | 1 | Completion flag |

## Verification
The bench models the comparator from a chosen input level. It tries the corner levels 0, 1023, 511 and 512, together with random levels. These show whether each bit is kept or dropped in the right order, and the 511/512 pair exercises the top-bit boundary. Divider codes 0, 5 and 7 and random divider codes pin down the period length and the clamp. Separate-oscillator runs use pulses on every cycle and on every third cycle, with pulses already present during the hold-off, which shows that the wait neither counts nor loses pulses. Directed aborts in the hold-off and mid-conversion, a start issued while busy, and flag clears before and at completion separate the cancel, ignore and set-over-clear rules.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_CONV = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sar_tick_gen.sv
// Produces one-cycle conversion period strobes from either a divided
// system clock or the separate oscillator enable.
module sar_tick_gen #(
  parameter int SEL_W   = 3,
  parameter int MAX_SEL = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rc_mode,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             rc_tick,
  output logic             tick
);
  localparam int CNT_W = MAX_SEL + 2;

  logic [SEL_W-1:0] sel_eff;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             div_hit;

  always_comb begin
    sel_eff = (div_sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : div_sel;
    limit   = (CNT_W'(2) << sel_eff) - CNT_W'(1);
    div_hit = (cnt >= limit);
    tick    = run && (rc_mode ? rc_tick : div_hit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || rc_mode) begin
      cnt <= '0;
    end else if (div_hit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sar_bit_engine.sv
// Successive-approximation register: one setup period, then one bit per
// period from the top bit down.
module sar_bit_engine #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] final_code,
  output logic             last
);
  localparam int PHW = $clog2(NBITS + 2);

  logic [PHW-1:0]   phase;
  logic [NBITS-1:0] sar;
  logic [NBITS-1:0] next_sar;
  int               bidx;

  always_comb begin
    bidx     = NBITS - int'(phase);
    next_sar = sar;
    if (phase == '0) begin
      next_sar = {1'b1, {(NBITS-1){1'b0}}};
    end else begin
      for (int i = 0; i < NBITS; i++) begin
        if (i == bidx)     next_sar[i] = cmp_in;
        if (i + 1 == bidx) next_sar[i] = 1'b1;
      end
    end
    last       = tick && (phase == PHW'(NBITS));
    final_code = next_sar;
    dac_code   = sar;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= '0;
      sar   <= '0;
    end else if (tick) begin
      sar   <= next_sar;
      phase <= phase + PHW'(1);
    end
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int NBITS    = 10,
  parameter int SEL_W    = 3,
  parameter int MAX_SEL  = 5,
  parameter int TCY_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic             flag_clr,
  input  logic             use_rc,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             rc_tick,
  input  logic             cmp_in,
  output logic             busy,
  output logic             sample_on,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] result,
  output logic             done_flag
);
  import sar_seq_pkg::*;

  localparam int WAIT_W = $clog2(TCY_CLKS + 1);

  seq_state_t       state;
  logic [WAIT_W-1:0] wait_cnt;
  logic             mode_q;
  logic             start, abort, finish, run, tick;
  logic [NBITS-1:0] final_code;

  assign start = (state == ST_IDLE) && go_set && !go_clr;
  assign abort = (state != ST_IDLE) && go_clr;
  assign run   = (state == ST_CONV);

  sar_tick_gen #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .rc_mode (mode_q),
    .div_sel (div_sel),
    .rc_tick (rc_tick),
    .tick    (tick)
  );

  sar_bit_engine #(.NBITS(NBITS)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .clear      (!run),
    .tick       (tick),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .final_code (final_code),
    .last       (finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wait_cnt  <= '0;
      mode_q    <= 1'b0;
      busy      <= 1'b0;
      sample_on <= 1'b1;
      result    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q    <= use_rc;
            wait_cnt  <= '0;
            busy      <= 1'b1;
            sample_on <= 1'b0;
            state     <= use_rc ? ST_HOLD : ST_CONV;
          end
        end
        ST_HOLD: begin
          if (abort) begin
            state     <= ST_IDLE;
            busy      <= 1'b0;
            sample_on <= 1'b1;
          end else if (wait_cnt == WAIT_W'(TCY_CLKS - 1)) begin
            state <= ST_CONV;
          end else begin
            wait_cnt <= wait_cnt + WAIT_W'(1);
          end
        end
        ST_CONV: begin
          if (abort || finish) begin
            state     <= ST_IDLE;
            busy      <= 1'b0;
            sample_on <= 1'b1;
          end
          if (finish && !abort) result <= final_code;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b0;
    end else if (run && finish && !abort) begin
      done_flag <= 1'b1;
    end else if (flag_clr) begin
      done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int NBITS = 10,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             go_set,
  input logic             go_clr,
  input logic             flag_clr,
  input logic             use_rc,
  input logic [SEL_W-1:0] div_sel,
  input logic             rc_tick,
  input logic             cmp_in,
  input logic             busy,
  input logic             sample_on,
  input logic [NBITS-1:0] dac_code,
  input logic [NBITS-1:0] result,
  input logic             done_flag
);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && go_set && !go_clr) |=> (busy && !sample_on));

  p_switch_open_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sample_on);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (result != $past(result)) |-> $fell(busy));

  p_flag_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $fell(busy));

  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && go_clr && !flag_clr) |=>
      (!busy && sample_on && $stable(done_flag) && $stable(result)));

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !busy) |=> !done_flag);

  p_setup_code_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (dac_code == '0));
endmodule

bind sar_conv_seq sar_conv_chk #(.NBITS(NBITS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  localparam int TCY = 4;

  logic       clk = 1'b0;
  logic       rst, go_set, go_clr, flag_clr, use_rc, rc_tick;
  logic [2:0] div_sel;
  logic       cmp_in;
  logic       busy, sample_on, done_flag;
  logic [9:0] dac_code, result;
  logic [9:0] vin;

  int n_checks = 0;
  int n_fail   = 0;
  logic [9:0] exp_result;
  logic       exp_flag;

  always #4 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  sar_conv_seq #(.TCY_CLKS(TCY)) u0 (
    .clk(clk), .rst(rst), .go_set(go_set), .go_clr(go_clr),
    .flag_clr(flag_clr), .use_rc(use_rc), .div_sel(div_sel),
    .rc_tick(rc_tick), .cmp_in(cmp_in), .busy(busy),
    .sample_on(sample_on), .dac_code(dac_code), .result(result),
    .done_flag(done_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int sel);
    return 2 << ((sel > 5) ? 5 : sel);
  endfunction

  // One conversion; returns after completion or abort, sampled at negedge.
  task automatic run_conv(input bit rc, input int sel, input int rcper,
                          input int level, input int abort_at,
                          input int extra_go_at, input bit hold_fclr);
    int  n = period_of(sel);
    int  ticks = 0;
    bit  cons, done_now;
    @(negedge clk);
    use_rc = rc; div_sel = 3'(sel); vin = 10'(level);
    go_set = 1'b1; flag_clr = hold_fclr;
    @(posedge clk);
    @(negedge clk);
    go_set = 1'b0;
    check(busy === 1'b1 && sample_on === 1'b0, "R2 start", int'(busy), 1);
    for (int j = 1; j < 2000; j++) begin
      rc_tick = rc ? (j % rcper == 0) : ($urandom % 2 == 1);
      go_set  = (j == extra_go_at);
      go_clr  = (j == abort_at);
      cons    = rc ? (j >= TCY + 1 && rc_tick) : (j % n == 0);
      @(posedge clk);
      @(negedge clk);
      go_set = 1'b0;
      if (j == abort_at) begin
        go_clr = 1'b0;
        check(busy === 1'b0 && sample_on === 1'b1, "R10 abort stops", int'(busy), 0);
        check(result === exp_result, "R10 result kept", int'(result), int'(exp_result));
        check(done_flag === exp_flag, "R10 flag kept", int'(done_flag), int'(exp_flag));
        rc_tick = 1'b0; flag_clr = 1'b0;
        return;
      end
      if (cons) ticks++;
      if (cons && ticks == 1)
        check(dac_code === 10'h200, "R5 setup trial", int'(dac_code), 512);
      done_now = (ticks == 11);
      if (done_now) begin
        check(busy === 1'b0, rc ? "R4 rc end timing" : "R3 div end timing", int'(busy), 0);
        check(result === 10'(level), "R6 final code", int'(result), level);
        check(done_flag === 1'b1 && sample_on === 1'b1, "R8 done flag/switch",
              int'(done_flag), 1);
        exp_result = 10'(level); exp_flag = 1'b1;
        rc_tick = 1'b0; flag_clr = 1'b0;
        return;
      end
      if (busy !== 1'b1 || result !== exp_result) begin
        check(busy === 1'b1, rc ? "R4 still busy" : "R3 still busy", int'(busy), 1);
        check(result === exp_result, "R7 result held", int'(result), int'(exp_result));
        rc_tick = 1'b0; flag_clr = 1'b0;
        return;
      end
    end
    check(1'b0, "R3 no completion", 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; go_set = 0; go_clr = 0; flag_clr = 0; use_rc = 0;
    rc_tick = 0; div_sel = 0; vin = 0;
    exp_result = '0; exp_flag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy === 0 && done_flag === 0 && sample_on === 1, "R1 reset ctrl", int'(busy), 0);
    check(result === 0 && dac_code === 0, "R1 reset data", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 0 && sample_on === 1 && result === 0, "R1 after reset", int'(busy), 0);

    run_conv(0, 0, 1, 10'h2A5, -1, -1, 0);          // R3 fastest divider
    run_conv(0, 5, 1, 1023, -1, -1, 0);             // R3 largest divider, R6 all ones
    run_conv(0, 7, 1, 0, -1, -1, 0);                // R3 clamp, R6 all zeros
    run_conv(1, 0, 1, 512, -1, -1, 0);              // R4 tick every cycle
    run_conv(1, 0, 3, 511, -1, -1, 0);              // R4 sparse ticks

    // R11: explicit clear
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0; exp_flag = 1'b0;
    check(done_flag === 1'b0, "R11 flag cleared", int'(done_flag), 0);

    run_conv(0, 1, 1, 300, 5, -1, 0);               // R10 mid-conversion abort
    run_conv(1, 0, 1, 77, 2, -1, 0);                // R10 abort during hold-off
    run_conv(0, 1, 1, 640, -1, 3, 0);               // R9 start while busy ignored
    exp_flag = 1'b0;
    run_conv(0, 0, 1, 123, -1, -1, 1);              // R11 set beats clear

    // R10: simultaneous set and clear while idle
    @(negedge clk); go_set = 1'b1; go_clr = 1'b1;
    @(negedge clk); go_set = 1'b0; go_clr = 1'b0;
    check(busy === 1'b0 && sample_on === 1'b1, "R10 clear wins", int'(busy), 0);

    for (int k = 0; k < 20; k++) begin
      run_conv(1'($urandom % 2), int'($urandom % 8), int'($urandom % 4) + 1,
               int'($urandom % 1024), -1, -1, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule